// File: doc/BRIEF.md
# Accumulator ALU with Selective Flag Update

This block is the arithmetic and logic stage of an 8-bit accumulator datapath. On every clock it takes the accumulator byte, a second operand byte, the current carry and half-carry flags and a 5-bit operation code. One cycle later it presents a result byte and a write strobe for that result. It also presents five flag values (sign, zero, half-carry, parity and carry), each paired with its own update-enable bit. The surrounding datapath fetches the operands, writes the result back only when the strobe is high, and merges a flag only when its enable bit is set. Each operation group touches only the flags that belong to it.

The operations are binary add, add with carry, subtract, subtract with borrow, AND, XOR, OR, compare, increment, decrement, circular and through-carry rotates in both directions, accumulator complement, carry complement, carry set and decimal adjust. The 16-bit register-pair add lives elsewhere. This block applies only its carry contract: the carry out of bit 15 is presented on a dedicated input, and the block turns it into a carry-only flag update.

Top module: `acc_alu8`

## Requirements
- R1: While `rst` is high, every output is 0 after the next rising clock edge. In normal operation, the outputs reflect the inputs sampled at the previous rising edge.
- R2: Op codes 0 (add) and 1 (add with carry) give `acc + opnd (+ cy_i)`. The result is written, all five flags are enabled, C is the carry out of bit 7 and AC is the carry out of bit 3.
- R3: Op codes 2 (subtract) and 3 (subtract with borrow) give `acc - opnd (- cy_i)`. The result is written and all five flags are enabled. C is 1 on a borrow out of bit 7, and AC is 1 on a borrow out of bit 3.
- R4: Op code 7 (compare) sets flags exactly as op code 2 would, and `res_o` shows the difference. However, `res_we_o` is 0.
- R5: Op codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result of `acc` and `opnd`. They enable all five flags and force C and AC to 0.
- R6: Op codes 8 (increment) and 9 (decrement) act on `opnd_i` and write the result. They enable S, Z, P and AC but not C. AC is 1 when the low nibble of the operand is 0xF (increment) or 0x0 (decrement).
- R7: Op code 10 rotates `acc` left with bit 7 going to bit 0. Op code 11 rotates it right with bit 0 going to bit 7. In both cases C takes the bit shifted out, and C is the only flag enabled.
- R8: Op code 12 shifts `acc` left, with `cy_i` entering bit 0. Op code 13 shifts it right, with `cy_i` entering bit 7. C takes the bit shifted out and is the only flag enabled.
- R9: Op code 14 writes `~acc` and enables no flag. Op code 15 enables only C, with value `~cy_i`. Op code 16 enables only C, with value 1. Neither 15 nor 16 writes a result.
- R10: Op code 17 (decimal adjust) first adds 0x06 when the low nibble exceeds 9 or `ac_i` is 1. It then adds 0x60 when the intermediate high nibble exceeds 9, when `cy_i` is 1, or when the first step carried out of bit 7. C is set exactly when the second step applies. AC is the carry out of bit 3 from the first step. The result is written and all five flags are enabled.
- R11: Op code 18 enables only C, with value `wide_cy_i`, and writes no result.
- R12: The flag vector layout is bit 4 = S, 3 = Z, 2 = AC, 1 = P, 0 = C. S is result bit 7, Z is result == 0 and P is 1 for an even number of ones. A flag whose enable bit is 0 reads 0. Op codes 15, 16, 18 and 19 to 31 drive `res_o` to 0. Codes 19 to 31 write nothing and enable no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand (register, memory or immediate byte) |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| wide_cy_i | input | 1 | Carry out of bit 15 from the external pair add |
| res_o | output | 8 | Result byte |
| res_we_o | output | 1 | Result write strobe |
| flags_o | output | 5 | Flag values {S, Z, AC, P, C} |
| flag_we_o | output | 5 | Per-flag update enables, same layout |

## Verification
The adder paths are driven with operand pairs chosen to separate the two carry points. Some pairs carry out of bit 3 but not bit 7, and others do the reverse. Some subtractions borrow, and some give an exact zero, so that C, AC and Z are each checked on their own. The carry-dependent operations (add with carry, subtract with borrow, the through-carry rotates and decimal adjust) are each tried with the incoming carry both clear and set, so that a design ignoring the carry input would show a mismatch. Decimal adjust is given inputs that need no correction, only the low correction, only the high correction, and both corrections. A broad pseudo-random sweep then covers every defined and undefined op code.

// File: rtl/accalu_pkg.sv
package accalu_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_CMC = 5'd15,
    OP_STC = 5'd16, OP_DAA = 5'd17, OP_WCY = 5'd18
  } alu_op_e;

  localparam int FLG_C  = 0;
  localparam int FLG_P  = 1;
  localparam int FLG_AC = 2;
  localparam int FLG_Z  = 3;
  localparam int FLG_S  = 4;
  localparam int NFLG   = 5;
endpackage

// File: rtl/accalu_addsub.sv
// Shared adder for add, subtract, increment and decrement.
// Subtraction is add of the inverted operand; carries are returned as borrows.
module accalu_addsub #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          hout_o
);
  logic [DW-1:0] ym;
  logic          ci;
  logic [DW:0]   full;
  logic [NIB:0]  half;

  always_comb begin
    ym     = sub_i ? ~y_i : y_i;
    ci     = sub_i ? ~cin_i : cin_i;
    full   = {1'b0, x_i} + {1'b0, ym} + (DW+1)'(ci);
    half   = {1'b0, x_i[NIB-1:0]} + {1'b0, ym[NIB-1:0]} + (NIB+1)'(ci);
    sum_o  = full[DW-1:0];
    cout_o = full[DW] ^ sub_i;
    hout_o = half[NIB] ^ sub_i;
  end
endmodule

// File: rtl/accalu_bitops.sv
// Bitwise operations, rotates and accumulator complement.
module accalu_bitops
  import accalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] r_o,
  output logic          cy_o
);
  always_comb begin
    r_o  = '0;
    cy_o = 1'b0;
    case (op_i)
      OP_AND: r_o = a_i & b_i;
      OP_XOR: r_o = a_i ^ b_i;
      OP_OR:  r_o = a_i | b_i;
      OP_RLC: begin r_o = {a_i[DW-2:0], a_i[DW-1]}; cy_o = a_i[DW-1]; end
      OP_RRC: begin r_o = {a_i[0], a_i[DW-1:1]};    cy_o = a_i[0];    end
      OP_RAL: begin r_o = {a_i[DW-2:0], cin_i};     cy_o = a_i[DW-1]; end
      OP_RAR: begin r_o = {cin_i, a_i[DW-1:1]};     cy_o = a_i[0];    end
      OP_CMA: r_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/accalu_decadj.sv
// Two-step decimal correction of a byte holding two BCD digits.
module accalu_decadj #(
  parameter int NIB = 4
) (
  input  logic [2*NIB-1:0] a_i,
  input  logic             cy_i,
  input  logic             ac_i,
  output logic [2*NIB-1:0] r_o,
  output logic             cy_o,
  output logic             ac_o
);
  localparam int BW = 2 * NIB;
  localparam logic [BW-1:0] LO_FIX = BW'(6);
  localparam logic [BW-1:0] HI_FIX = BW'(6) << NIB;

  logic          lo_adj, hi_adj;
  logic [BW:0]   step1;
  logic [NIB:0]  lo_sum;

  always_comb begin
    lo_adj = (a_i[NIB-1:0] > NIB'(9)) || ac_i;
    step1  = {1'b0, a_i} + {1'b0, (lo_adj ? LO_FIX : '0)};
    lo_sum = {1'b0, a_i[NIB-1:0]} + {1'b0, (lo_adj ? LO_FIX[NIB-1:0] : '0)};
    hi_adj = (step1[BW-1:NIB] > NIB'(9)) || cy_i || step1[BW];
    r_o    = step1[BW-1:0] + (hi_adj ? HI_FIX : '0);
    cy_o   = hi_adj;
    ac_o   = lo_sum[NIB];
  end
endmodule

// File: rtl/acc_alu8.sv
// Accumulator ALU: operation select, flag generation with per-flag
// enables, and a registered output stage.
module acc_alu8
  import accalu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  opnd_i,
  input  logic           cy_i,
  input  logic           ac_i,
  input  logic           wide_cy_i,
  output logic [DW-1:0]  res_o,
  output logic           res_we_o,
  output logic [NFLG-1:0] flags_o,
  output logic [NFLG-1:0] flag_we_o
);
  localparam int NIB = DW / 2;
  localparam logic [NFLG-1:0] ALL_F  = '1;
  localparam logic [NFLG-1:0] ONLY_C = NFLG'(1) << FLG_C;
  localparam logic [NFLG-1:0] NO_C   = ALL_F & ~ONLY_C;

  // adder operand selection
  logic [DW-1:0] as_x, as_y, as_sum;
  logic          as_cin, as_sub, as_cout, as_hout;

  always_comb begin
    as_x   = acc_i;
    as_y   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op_i)
      OP_ADC: as_cin = cy_i;
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = cy_i; end
      OP_INC: begin as_x = opnd_i; as_y = DW'(1); end
      OP_DEC: begin as_x = opnd_i; as_y = DW'(1); as_sub = 1'b1; end
      default: ;
    endcase
  end

  accalu_addsub #(.DW(DW), .NIB(NIB)) u_addsub (
    .x_i(as_x), .y_i(as_y), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .cout_o(as_cout), .hout_o(as_hout)
  );

  logic [DW-1:0] bo_r;
  logic          bo_cy;
  accalu_bitops #(.DW(DW)) u_bitops (
    .op_i(op_i), .a_i(acc_i), .b_i(opnd_i), .cin_i(cy_i),
    .r_o(bo_r), .cy_o(bo_cy)
  );

  logic [DW-1:0] da_r;
  logic          da_cy, da_ac;
  accalu_decadj #(.NIB(NIB)) u_decadj (
    .a_i(acc_i), .cy_i(cy_i), .ac_i(ac_i),
    .r_o(da_r), .cy_o(da_cy), .ac_o(da_ac)
  );

  // per-operation result, strobe, carry, half-carry and flag mask
  logic [DW-1:0]   nx_res;
  logic            nx_we, nx_cy, nx_ac;
  logic [NFLG-1:0] nx_msk, nx_flg;

  always_comb begin
    nx_res = '0;
    nx_we  = 1'b0;
    nx_cy  = 1'b0;
    nx_ac  = 1'b0;
    nx_msk = '0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        nx_res = as_sum; nx_we = 1'b1; nx_cy = as_cout; nx_ac = as_hout;
        nx_msk = ALL_F;
      end
      OP_CMP: begin
        nx_res = as_sum; nx_cy = as_cout; nx_ac = as_hout; nx_msk = ALL_F;
      end
      OP_INC, OP_DEC: begin
        nx_res = as_sum; nx_we = 1'b1; nx_ac = as_hout; nx_msk = NO_C;
      end
      OP_AND, OP_XOR, OP_OR: begin
        nx_res = bo_r; nx_we = 1'b1; nx_msk = ALL_F;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        nx_res = bo_r; nx_we = 1'b1; nx_cy = bo_cy; nx_msk = ONLY_C;
      end
      OP_CMA: begin nx_res = bo_r; nx_we = 1'b1; end
      OP_CMC: begin nx_cy = ~cy_i;    nx_msk = ONLY_C; end
      OP_STC: begin nx_cy = 1'b1;     nx_msk = ONLY_C; end
      OP_WCY: begin nx_cy = wide_cy_i; nx_msk = ONLY_C; end
      OP_DAA: begin
        nx_res = da_r; nx_we = 1'b1; nx_cy = da_cy; nx_ac = da_ac;
        nx_msk = ALL_F;
      end
      default: ;
    endcase
    nx_flg         = '0;
    nx_flg[FLG_S]  = nx_res[DW-1];
    nx_flg[FLG_Z]  = (nx_res == '0);
    nx_flg[FLG_AC] = nx_ac;
    nx_flg[FLG_P]  = ~^nx_res;
    nx_flg[FLG_C]  = nx_cy;
    nx_flg         = nx_flg & nx_msk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_we_o  <= 1'b0;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      res_o     <= nx_res;
      res_we_o  <= nx_we;
      flags_o   <= nx_flg;
      flag_we_o <= nx_msk;
    end
  end

  // R4
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_CMP) |-> (!res_we_o && flag_we_o == ALL_F));

  // R6
  incdec_keep_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
      |-> (!flag_we_o[FLG_C] && !flags_o[FLG_C] && res_we_o));

  // R5
  logic_clears_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == OP_AND || $past(op_i) == OP_XOR ||
                     $past(op_i) == OP_OR))
      |-> (flag_we_o[FLG_C] && !flags_o[FLG_C] && !flags_o[FLG_AC]));

  // R9
  stc_sets_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_STC)
      |-> (flags_o[FLG_C] && flag_we_o == ONLY_C && !res_we_o));

  // R9
  cma_invert_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_CMA)
      |-> (res_o == ~$past(acc_i) && res_we_o && flag_we_o == '0));

  // R11
  wide_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) == OP_WCY)
      |-> (flags_o[FLG_C] == $past(wide_cy_i) && flag_we_o == ONLY_C));
endmodule

// File: tb/acc_alu8_test.sv
module acc_alu8_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0;
  logic       cy_i = 1'b0, ac_i = 1'b0, wide_cy_i = 1'b0;
  logic [7:0] res_o;
  logic       res_we_o;
  logic [4:0] flags_o, flag_we_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  acc_alu8 uut (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .cy_i(cy_i), .ac_i(ac_i), .wide_cy_i(wide_cy_i),
    .res_o(res_o), .res_we_o(res_we_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] res;
    logic       we;
    logic [4:0] flg;
    logic [4:0] msk;
  } exp_t;

  exp_t sb[$];

  function automatic string rtag(int op);
    case (op)
      0, 1:       return "R2";
      2, 3:       return "R3";
      7:          return "R4";
      4, 5, 6:    return "R5";
      8, 9:       return "R6";
      10, 11:     return "R7";
      12, 13:     return "R8";
      14, 15, 16: return "R9";
      17:         return "R10";
      18:         return "R11";
      default:    return "R12";
    endcase
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(int op, int a, int b, int c, int h, int w);
    exp_t e;
    int r = 0, cy = 0, hc = 0, we = 0, t = 0, lo = 0, hi = 0;
    logic [4:0] m = 5'h00;
    logic [7:0] rb;
    case (op)
      0:  begin r = a + b;     cy = (r > 255); hc = ((a%16)+(b%16)) > 15;   we = 1; m = 5'h1F; end
      1:  begin r = a + b + c; cy = (r > 255); hc = ((a%16)+(b%16)+c) > 15; we = 1; m = 5'h1F; end
      2:  begin r = a - b;     cy = (a < b);   hc = (a%16) < (b%16);       we = 1; m = 5'h1F; end
      3:  begin r = a - b - c; cy = (a < b+c); hc = (a%16) < ((b%16)+c);   we = 1; m = 5'h1F; end
      7:  begin r = a - b;     cy = (a < b);   hc = (a%16) < (b%16);       we = 0; m = 5'h1F; end
      4:  begin r = a & b; we = 1; m = 5'h1F; end
      5:  begin r = a ^ b; we = 1; m = 5'h1F; end
      6:  begin r = a | b; we = 1; m = 5'h1F; end
      8:  begin r = b + 1; hc = (b%16) == 15; we = 1; m = 5'h1E; end
      9:  begin r = b - 1; hc = (b%16) == 0;  we = 1; m = 5'h1E; end
      10: begin r = ((a*2)%256) + a/128;       cy = a/128; we = 1; m = 5'h01; end
      11: begin r = a/2 + (a%2)*128;           cy = a%2;   we = 1; m = 5'h01; end
      12: begin r = ((a*2)%256) + c;           cy = a/128; we = 1; m = 5'h01; end
      13: begin r = a/2 + c*128;               cy = a%2;   we = 1; m = 5'h01; end
      14: begin r = 255 - a; we = 1; m = 5'h00; end
      15: begin cy = 1 - c; m = 5'h01; end
      16: begin cy = 1;     m = 5'h01; end
      18: begin cy = w;     m = 5'h01; end
      17: begin
        lo = ((a%16) > 9) || (h != 0);
        t  = a + (lo ? 6 : 0);
        hi = (((t/16)%16) > 9) || (c != 0) || (t > 255);
        r  = (t%256) + (hi ? 96 : 0);
        cy = hi;
        hc = ((a%16) + (lo ? 6 : 0)) > 15;
        we = 1; m = 5'h1F;
      end
      default: ;
    endcase
    rb    = 8'(r);
    e.op  = 5'(op);
    e.res = rb;
    e.we  = 1'(we);
    e.msk = m;
    e.flg = {rb[7], (rb == 8'h00), 1'(hc), ~^rb, 1'(cy)} & m;
    return e;
  endfunction

  task automatic drive(int op, int a, int b, int c, int h, int w);
    @(negedge clk);
    op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(b);
    cy_i = 1'(c); ac_i = 1'(h); wide_cy_i = 1'(w);
    sb.push_back(model(op, a, b, c, h, w));
  endtask

  // monitor: compares one result per clock after the registered stage settles
  always begin
    @(posedge clk);
    #2;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (res_o !== e.res || res_we_o !== e.we || flags_o !== e.flg || flag_we_o !== e.msk) begin
        n_bad++;
        $display("FAIL %s op=%0d: got res=%02h we=%0b flg=%05b msk=%05b, exp res=%02h we=%0b flg=%05b msk=%05b",
                 rtag(int'(e.op)), e.op, res_o, res_we_o, flags_o, flag_we_o,
                 e.res, e.we, e.flg, e.msk);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    op_i = 5'd16; acc_i = 8'hFF; cy_i = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (res_o !== 8'h00 || res_we_o !== 1'b0 || flags_o !== 5'h00 || flag_we_o !== 5'h00) begin
      n_bad++;
      $display("FAIL R1 reset: got res=%02h we=%0b flg=%05b msk=%05b, exp all zero",
               res_o, res_we_o, flags_o, flag_we_o);
    end
    @(negedge clk);
    rst = 1'b0;

    // R2: carry out of bit 7 and bit 3 together, carry only from bit 3, with carry in
    drive(0, 8'h3A, 8'hC6, 0, 0, 0);
    drive(0, 8'h08, 8'h08, 1, 0, 0);
    drive(1, 8'h0F, 8'h00, 1, 0, 0);
    drive(1, 8'hF0, 8'h10, 0, 0, 0);
    // R3: equal, borrow, borrow via carry in
    drive(2, 8'h55, 8'h55, 1, 0, 0);
    drive(2, 8'h10, 8'h20, 0, 0, 0);
    drive(3, 8'h20, 8'h1F, 1, 0, 0);
    drive(3, 8'h00, 8'h00, 1, 0, 0);
    // R4: compare keeps accumulator
    drive(7, 8'h05, 8'h09, 0, 0, 0);
    drive(7, 8'h80, 8'h80, 1, 0, 0);
    // R5: logic ops clear carry even when carry in is set
    drive(4, 8'hF0, 8'h3C, 1, 1, 0);
    drive(5, 8'hAA, 8'hAA, 1, 1, 0);
    drive(6, 8'h81, 8'h02, 1, 0, 0);
    // R6: wrap cases, carry input ignored
    drive(8, 8'h00, 8'hFF, 1, 0, 0);
    drive(9, 8'h00, 8'h00, 1, 0, 0);
    drive(8, 8'h00, 8'h7F, 0, 0, 0);
    // R7 and R8: rotates with both carry values
    drive(10, 8'h81, 0, 0, 0, 0);
    drive(11, 8'h01, 0, 0, 0, 0);
    drive(12, 8'h40, 0, 1, 0, 0);
    drive(12, 8'h80, 0, 0, 0, 0);
    drive(13, 8'h02, 0, 1, 0, 0);
    drive(13, 8'h01, 0, 0, 0, 0);
    // R9
    drive(14, 8'h5A, 0, 1, 0, 0);
    drive(15, 0, 0, 1, 0, 0);
    drive(15, 0, 0, 0, 0, 0);
    drive(16, 0, 0, 0, 0, 0);
    // R10: none, low only, high only, both, via flags, overflow of first step
    drive(17, 8'h15, 0, 0, 0, 0);
    drive(17, 8'h1B, 0, 0, 0, 0);
    drive(17, 8'hA5, 0, 0, 0, 0);
    drive(17, 8'h9B, 0, 0, 0, 0);
    drive(17, 8'h12, 0, 1, 1, 0);
    drive(17, 8'hFA, 0, 0, 0, 0);
    // R11
    drive(18, 0, 0, 0, 0, 1);
    drive(18, 0, 0, 1, 0, 0);
    // R12: undefined codes
    drive(19, 8'hFF, 8'hFF, 1, 1, 1);
    drive(31, 8'h12, 8'h34, 0, 0, 0);

    // sweep across every op code
    for (int i = 0; i < 1200; i++) begin
      drive(int'($urandom_range(31, 0)), int'($urandom_range(255, 0)),
            int'($urandom_range(255, 0)), int'($urandom_range(1, 0)),
            int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
    end

    repeat (4) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule